// File: doc/BRIEF.md
# Multi-Row Activation Command Sequencer

This block drives a simplified DRAM command bus for one bank at a time. Its aim is to leave several rows of one subarray open at once. For each request it issues an activate to a first row. A precharge follows after a deliberately shortened gap, and a second activate to another row follows after another shortened gap. Because the precharge has not completed, both row decodes remain asserted, and the sense amplifiers work on every opened row together. Every other interval on the bus, such as activate-to-column, write recovery, row active time and precharge recovery, is held at or above its nominal value. These nominal values come from cycle-count registers that can be loaded while the block is idle.

The block supports three modes:
- **Copy:** it only opens the rows and waits for the sense amplifiers to restore one common value into all of them.
- **Bulk write:** a single write after the double activation lands in every opened row.
- **Signature:** each row of the group first gets a pattern write with nominal timing. The double activation then runs, and one row is read back with nominal timing. This whole pass repeats a requested number of times.

Every sequence ends with a precharge. The block then waits out the precharge recovery time before it raises done and returns to idle. Requests use a valid/ready handshake.

Top module: `mra_seq_top`

## Requirements
- R1: A request drives ACT to row A, then PRE, then ACT to row B. The PRE comes exactly `sap` cycles after the first ACT, and the second ACT comes exactly `spa` cycles after the PRE.
- R2: The closing PRE comes when two conditions are met. It is at least `ras` cycles after the second ACT, and, in a mode with a column access, it is at least `wrr` cycles after that access. The `done` output is a one-cycle pulse exactly `rp` cycles after the closing PRE, with `busy` high in that cycle and low in the next.
- R3: Copy mode (mode code 0, and also the unused code 3) issues no RD or WR. Its closing PRE comes exactly `ras` cycles after the second ACT.
- R4: Bulk-write mode (mode code 1) issues exactly one WR. It comes `rcd` cycles after the second ACT, with `cmd_addr` equal to the requested column and `wr_stb` high. The closing PRE then comes at max(`rcd`+`wrr`, `ras`) cycles after the second ACT.
- R5: Signature mode (mode code 2) runs one pass per repetition. Each pass first writes row A and then row B. Each of these writes is an ACT, a WR `rcd` later, and a PRE at max(`rcd`+`wrr`, `ras`) after the ACT. The next command comes `rp` after each PRE. The pass then runs the R1 sequence and a RD of the requested column `rcd` after the second ACT, with `rd_stb` high. Passes repeat `req_reps` times, and a count of 0 gives one pass. Counts up to at least 100 are supported.
- R6: `req_ready` is high only while idle. A request is taken in a cycle with `req_valid` and `req_ready` both high. Its first ACT appears in the following cycle, and `req_ready` stays low until done has been given.
- R7: Each timing register is written in a cycle with `cfg_we` high while idle. The register is chosen by `cfg_sel` (0 `sap`, 1 `spa`, 2 `rcd`, 3 `ras`, 4 `rp`, 5 `wrr`). Writes while busy have no effect. A programmed value of 0 behaves as 1.
- R8: Command codes on `cmd_o` are NOP=0, ACT=1, PRE=2, RD=3, WR=4. Exactly one command is driven per cycle, and NOP is driven in every cycle without a command. During NOP, `cmd_bank` and `cmd_addr` are 0. PRE carries address 0. Every non-NOP command carries the requested bank. The strobes are high only together with their own command.
- R9: After reset the outputs show NOP, ready high, busy and done low. The timing registers hold their parameter defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Timing register write enable |
| cfg_sel | input | 3 | Timing register select |
| cfg_val | input | GAP_W | Cycle count to store |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_bank | input | BANK_W | Target bank |
| req_row_a | input | ROW_W | First activated row |
| req_row_b | input | ROW_W | Second activated row (the one read back) |
| req_col | input | COL_W | Column for WR or RD |
| req_mode | input | 2 | 0 copy, 1 bulk write, 2 signature |
| req_reps | input | REP_W | Signature pass count |
| cmd_o | output | 3 | Command code |
| cmd_bank | output | BANK_W | Bank of the command |
| cmd_addr | output | ADDR_W | Row for ACT, column for RD/WR, else 0 |
| wr_stb | output | 1 | Write data strobe, with WR |
| rd_stb | output | 1 | Read data capture strobe, with RD |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-request pulse |

## Verification
All state is a phase register and two down-counters, so nearly every fault reaches the bus within the next programmed gap. A wrong phase shows as a wrong command code or row address on the next non-NOP cycle. A wrong counter load shows as the next command one or more cycles away from its computed position. A repeat counter that is off shows only at the end of a signature request, as an extra or missing pattern pass and a shifted done pulse. A timing register written while busy shows on the next request as moved command positions.

// File: rtl/mra_pkg.sv
package mra_pkg;

    localparam int GAP_W = 6;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_PRE = 3'd2,
        CMD_RD  = 3'd3,
        CMD_WR  = 3'd4
    } cmd_e;

    typedef enum logic [1:0] {
        MODE_COPY = 2'd0,
        MODE_BULK = 2'd1,
        MODE_SIG  = 2'd2
    } mode_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PW_ACT,
        ST_PW_WR,
        ST_PW_PRE,
        ST_ACT1,
        ST_PRE1,
        ST_ACT2,
        ST_ACCESS,
        ST_CLOSE,
        ST_FIN
    } seq_st_e;

    typedef struct packed {
        logic [GAP_W-1:0] sap;   // shortened ACT to PRE
        logic [GAP_W-1:0] spa;   // shortened PRE to ACT
        logic [GAP_W-1:0] rcd;   // ACT to column command
        logic [GAP_W-1:0] ras;   // ACT to closing PRE
        logic [GAP_W-1:0] rp;    // PRE recovery
        logic [GAP_W-1:0] wrr;   // column command to PRE
    } timing_t;

    function automatic logic [GAP_W-1:0] clamp1(input logic [GAP_W-1:0] v);
        return (v == '0) ? GAP_W'(1) : v;
    endfunction

    // value to load into a down-counter so the next command lands v cycles later
    function automatic logic [GAP_W-1:0] gap_m1(input logic [GAP_W-1:0] v);
        return clamp1(v) - GAP_W'(1);
    endfunction

    function automatic mode_e decode_mode(input logic [1:0] m);
        case (m)
            2'd1:    return MODE_BULK;
            2'd2:    return MODE_SIG;
            default: return MODE_COPY;
        endcase
    endfunction

endpackage

// File: rtl/mra_cfg_regs.sv
module mra_cfg_regs
    import mra_pkg::*;
#(
    parameter logic [GAP_W-1:0] DEF_SAP = 2,
    parameter logic [GAP_W-1:0] DEF_SPA = 1,
    parameter logic [GAP_W-1:0] DEF_RCD = 4,
    parameter logic [GAP_W-1:0] DEF_RAS = 10,
    parameter logic [GAP_W-1:0] DEF_RP  = 4,
    parameter logic [GAP_W-1:0] DEF_WRR = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [2:0]       sel,
    input  logic [GAP_W-1:0] val,
    input  logic             idle,
    output timing_t          tim
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tim.sap <= clamp1(DEF_SAP);
            tim.spa <= clamp1(DEF_SPA);
            tim.rcd <= clamp1(DEF_RCD);
            tim.ras <= clamp1(DEF_RAS);
            tim.rp  <= clamp1(DEF_RP);
            tim.wrr <= clamp1(DEF_WRR);
        end else if (we && idle) begin
            case (sel)
                3'd0:    tim.sap <= clamp1(val);
                3'd1:    tim.spa <= clamp1(val);
                3'd2:    tim.rcd <= clamp1(val);
                3'd3:    tim.ras <= clamp1(val);
                3'd4:    tim.rp  <= clamp1(val);
                3'd5:    tim.wrr <= clamp1(val);
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/mra_gap_timer.sv
module mra_gap_timer
    import mra_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [GAP_W-1:0] load_val,
    input  logic             ras_start,
    input  logic [GAP_W-1:0] ras_val,
    output logic             gap_zero,
    output logic             ras_zero
);

    logic [GAP_W-1:0] gap_cnt;
    logic [GAP_W-1:0] ras_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_cnt <= '0;
            ras_cnt <= '0;
        end else begin
            if (load)
                gap_cnt <= load_val;
            else if (gap_cnt != '0)
                gap_cnt <= gap_cnt - 1'b1;

            if (ras_start)
                ras_cnt <= ras_val;
            else if (ras_cnt != '0)
                ras_cnt <= ras_cnt - 1'b1;
        end
    end

    assign gap_zero = (gap_cnt == '0);
    assign ras_zero = (ras_cnt == '0);

endmodule

// File: rtl/mra_fsm.sv
module mra_fsm
    import mra_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 10,
    parameter int COL_W  = 6,
    parameter int REP_W  = 8,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  timing_t           tim,
    input  logic              gap_zero,
    input  logic              ras_zero,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row_a,
    input  logic [ROW_W-1:0]  req_row_b,
    input  logic [COL_W-1:0]  req_col,
    input  logic [1:0]        req_mode,
    input  logic [REP_W-1:0]  req_reps,
    output cmd_e              cmd,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              wr_stb,
    output logic              rd_stb,
    output logic              busy,
    output logic              done,
    output logic              load,
    output logic [GAP_W-1:0]  load_val,
    output logic              ras_start,
    output logic [GAP_W-1:0]  ras_val
);

    seq_st_e           st_q, st_n;
    logic              pw_q, pw_n;
    logic [REP_W-1:0]  reps_q, reps_n;
    logic [BANK_W-1:0] bank_q;
    logic [ROW_W-1:0]  row_a_q, row_b_q;
    logic [COL_W-1:0]  col_q;
    mode_e             mode_q;
    logic              accept;

    assign req_ready = (st_q == ST_IDLE);
    assign busy      = (st_q != ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign ras_val   = gap_m1(tim.ras);
    assign cmd_bank  = (cmd != CMD_NOP) ? bank_q : '0;

    always_comb begin
        st_n      = st_q;
        pw_n      = pw_q;
        reps_n    = reps_q;
        cmd       = CMD_NOP;
        cmd_addr  = '0;
        wr_stb    = 1'b0;
        rd_stb    = 1'b0;
        load      = 1'b0;
        load_val  = '0;
        ras_start = 1'b0;
        done      = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (req_valid)
                    st_n = (decode_mode(req_mode) == MODE_SIG) ? ST_PW_ACT : ST_ACT1;
            end
            ST_PW_ACT: if (gap_zero) begin
                cmd       = CMD_ACT;
                cmd_addr  = pw_q ? ADDR_W'(row_b_q) : ADDR_W'(row_a_q);
                load      = 1'b1;
                load_val  = gap_m1(tim.rcd);
                ras_start = 1'b1;
                st_n      = ST_PW_WR;
            end
            ST_PW_WR: if (gap_zero) begin
                cmd      = CMD_WR;
                cmd_addr = ADDR_W'(col_q);
                wr_stb   = 1'b1;
                load     = 1'b1;
                load_val = gap_m1(tim.wrr);
                st_n     = ST_PW_PRE;
            end
            ST_PW_PRE: if (gap_zero && ras_zero) begin
                cmd      = CMD_PRE;
                load     = 1'b1;
                load_val = gap_m1(tim.rp);
                pw_n     = !pw_q;
                st_n     = pw_q ? ST_ACT1 : ST_PW_ACT;
            end
            ST_ACT1: if (gap_zero) begin
                cmd      = CMD_ACT;
                cmd_addr = ADDR_W'(row_a_q);
                load     = 1'b1;
                load_val = gap_m1(tim.sap);
                st_n     = ST_PRE1;
            end
            ST_PRE1: if (gap_zero) begin
                cmd      = CMD_PRE;
                load     = 1'b1;
                load_val = gap_m1(tim.spa);
                st_n     = ST_ACT2;
            end
            ST_ACT2: if (gap_zero) begin
                cmd       = CMD_ACT;
                cmd_addr  = ADDR_W'(row_b_q);
                load      = 1'b1;
                ras_start = 1'b1;
                if (mode_q == MODE_COPY) begin
                    load_val = gap_m1(tim.ras);
                    st_n     = ST_CLOSE;
                end else begin
                    load_val = gap_m1(tim.rcd);
                    st_n     = ST_ACCESS;
                end
            end
            ST_ACCESS: if (gap_zero) begin
                cmd_addr = ADDR_W'(col_q);
                if (mode_q == MODE_BULK) begin
                    cmd    = CMD_WR;
                    wr_stb = 1'b1;
                end else begin
                    cmd    = CMD_RD;
                    rd_stb = 1'b1;
                end
                load     = 1'b1;
                load_val = gap_m1(tim.wrr);
                st_n     = ST_CLOSE;
            end
            ST_CLOSE: if (gap_zero && ras_zero) begin
                cmd      = CMD_PRE;
                load     = 1'b1;
                load_val = gap_m1(tim.rp);
                if (mode_q == MODE_SIG && reps_q > REP_W'(1)) begin
                    reps_n = reps_q - 1'b1;
                    st_n   = ST_PW_ACT;
                end else begin
                    st_n = ST_FIN;
                end
            end
            ST_FIN: if (gap_zero) begin
                done = 1'b1;
                st_n = ST_IDLE;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            pw_q    <= 1'b0;
            reps_q  <= '0;
            bank_q  <= '0;
            row_a_q <= '0;
            row_b_q <= '0;
            col_q   <= '0;
            mode_q  <= MODE_COPY;
        end else begin
            st_q <= st_n;
            pw_q <= pw_n;
            if (accept) begin
                bank_q  <= req_bank;
                row_a_q <= req_row_a;
                row_b_q <= req_row_b;
                col_q   <= req_col;
                mode_q  <= decode_mode(req_mode);
                reps_q  <= (req_reps == '0) ? REP_W'(1) : req_reps;
                pw_q    <= 1'b0;
            end else begin
                reps_q <= reps_n;
            end
        end
    end

endmodule

// File: rtl/mra_seq_top.sv
module mra_seq_top
    import mra_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 10,
    parameter int COL_W  = 6,
    parameter int REP_W  = 8,
    parameter logic [GAP_W-1:0] DEF_SAP = 2,
    parameter logic [GAP_W-1:0] DEF_SPA = 1,
    parameter logic [GAP_W-1:0] DEF_RCD = 4,
    parameter logic [GAP_W-1:0] DEF_RAS = 10,
    parameter logic [GAP_W-1:0] DEF_RP  = 4,
    parameter logic [GAP_W-1:0] DEF_WRR = 4,
    localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [GAP_W-1:0]  cfg_val,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row_a,
    input  logic [ROW_W-1:0]  req_row_b,
    input  logic [COL_W-1:0]  req_col,
    input  logic [1:0]        req_mode,
    input  logic [REP_W-1:0]  req_reps,
    output logic [2:0]        cmd_o,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              wr_stb,
    output logic              rd_stb,
    output logic              busy,
    output logic              done
);

    timing_t          tim;
    logic             gap_zero, ras_zero;
    logic             load, ras_start;
    logic [GAP_W-1:0] load_val, ras_val;
    cmd_e             cmd;

    assign cmd_o = cmd;

    mra_cfg_regs #(
        .DEF_SAP(DEF_SAP), .DEF_SPA(DEF_SPA), .DEF_RCD(DEF_RCD),
        .DEF_RAS(DEF_RAS), .DEF_RP(DEF_RP),   .DEF_WRR(DEF_WRR)
    ) cfg_i (
        .clk  (clk),
        .rst  (rst),
        .we   (cfg_we),
        .sel  (cfg_sel),
        .val  (cfg_val),
        .idle (!busy),
        .tim  (tim)
    );

    mra_gap_timer tmr_i (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_val  (load_val),
        .ras_start (ras_start),
        .ras_val   (ras_val),
        .gap_zero  (gap_zero),
        .ras_zero  (ras_zero)
    );

    mra_fsm #(
        .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
        .REP_W(REP_W),   .ADDR_W(ADDR_W)
    ) fsm_i (
        .clk       (clk),
        .rst       (rst),
        .tim       (tim),
        .gap_zero  (gap_zero),
        .ras_zero  (ras_zero),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_bank  (req_bank),
        .req_row_a (req_row_a),
        .req_row_b (req_row_b),
        .req_col   (req_col),
        .req_mode  (req_mode),
        .req_reps  (req_reps),
        .cmd       (cmd),
        .cmd_bank  (cmd_bank),
        .cmd_addr  (cmd_addr),
        .wr_stb    (wr_stb),
        .rd_stb    (rd_stb),
        .busy      (busy),
        .done      (done),
        .load      (load),
        .load_val  (load_val),
        .ras_start (ras_start),
        .ras_val   (ras_val)
    );

endmodule

// File: rtl/mra_seq_chk.sv
module mra_seq_chk
    import mra_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [2:0] cmd_o,
    input logic       wr_stb,
    input logic       rd_stb,
    input logic       busy,
    input logic       done,
    input logic       req_valid,
    input logic       req_ready,
    input timing_t    tim
);

    p_idle_nop_r8: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (cmd_o == 3'(CMD_NOP)));

    p_wr_stb_r8: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> (cmd_o == 3'(CMD_WR)));

    p_rd_stb_r8: assert property (@(posedge clk) disable iff (rst)
        rd_stb |-> (cmd_o == 3'(CMD_RD)));

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    p_done_busy_r2: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    p_first_act_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (cmd_o == 3'(CMD_ACT)));

    p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(tim));

    p_gap_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
        (tim.sap != '0) && (tim.spa != '0) && (tim.rcd != '0) &&
        (tim.ras != '0) && (tim.rp != '0) && (tim.wrr != '0));

endmodule

bind mra_seq_top mra_seq_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .cmd_o     (cmd_o),
    .wr_stb    (wr_stb),
    .rd_stb    (rd_stb),
    .busy      (busy),
    .done      (done),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .tim       (tim)
);

// File: tb/mra_seq_top_tb_top.sv
module mra_seq_top_tb_top;

    localparam int BANK_W = 2;
    localparam int ROW_W  = 10;
    localparam int COL_W  = 6;
    localparam int REP_W  = 8;
    localparam int ADDR_W = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_we = 1'b0;
    logic [2:0]        cfg_sel = '0;
    logic [5:0]        cfg_val = '0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [BANK_W-1:0] req_bank = '0;
    logic [ROW_W-1:0]  req_row_a = '0;
    logic [ROW_W-1:0]  req_row_b = '0;
    logic [COL_W-1:0]  req_col = '0;
    logic [1:0]        req_mode = '0;
    logic [REP_W-1:0]  req_reps = '0;
    logic [2:0]        cmd_o;
    logic [BANK_W-1:0] cmd_bank;
    logic [ADDR_W-1:0] cmd_addr;
    logic              wr_stb, rd_stb, busy, done;

    mra_seq_top #(
        .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .REP_W(REP_W),
        .DEF_SAP(2), .DEF_SPA(1), .DEF_RCD(4), .DEF_RAS(10), .DEF_RP(4), .DEF_WRR(4)
    ) dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_val(cfg_val),
        .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank),
        .req_row_a(req_row_a), .req_row_b(req_row_b), .req_col(req_col),
        .req_mode(req_mode), .req_reps(req_reps), .cmd_o(cmd_o), .cmd_bank(cmd_bank),
        .cmd_addr(cmd_addr), .wr_stb(wr_stb), .rd_stb(rd_stb), .busy(busy), .done(done)
    );

    always #10 clk = ~clk;   // 50 MHz

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 0;

    // programmed timing values as written (raw, may be zero)
    int g_sap = 2, g_spa = 1, g_rcd = 4, g_ras = 10, g_rp = 4, g_wrr = 4;

    int exp_t [0:2047];
    int exp_c [0:2047];
    int exp_a [0:2047];
    int n_exp;
    int exp_done;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc >= 190000 && !finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual cycle=%0d expected below 190000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    function automatic int cl(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic check(input bit ok, input string what, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, expv);
        end
    endtask

    task automatic add_exp(input int t, input int c, input int a);
        exp_t[n_exp] = t;
        exp_c[n_exp] = c;
        exp_a[n_exp] = a;
        n_exp++;
    endtask

    // expected command trace, times relative to the accepting clock edge
    task automatic build_exp(input int mode, input int reps, input int ra, input int rb, input int col);
        int sap = cl(g_sap), spa = cl(g_spa), rcd = cl(g_rcd);
        int ras = cl(g_ras), rp = cl(g_rp), wrr = cl(g_wrr);
        int m = (mode == 3) ? 0 : mode;
        int np = (m == 2) ? ((reps == 0) ? 1 : reps) : 1;
        int t = 1;
        int p, t2;
        n_exp = 0;
        for (int rep = 0; rep < np; rep++) begin
            if (m == 2) begin
                for (int r = 0; r < 2; r++) begin
                    add_exp(t, 1, (r == 0) ? ra : rb);
                    add_exp(t + rcd, 4, col);
                    p = t + mx(rcd + wrr, ras);
                    add_exp(p, 2, 0);
                    t = p + rp;
                end
            end
            add_exp(t, 1, ra);
            add_exp(t + sap, 2, 0);
            t2 = t + sap + spa;
            add_exp(t2, 1, rb);
            if (m == 0) begin
                p = t2 + ras;
            end else begin
                add_exp(t2 + rcd, (m == 1) ? 4 : 3, col);
                p = t2 + mx(rcd + wrr, ras);
            end
            add_exp(p, 2, 0);
            t = p + rp;
        end
        exp_done = t;
    endtask

    task automatic cfg_write(input int sel, input int val);
        @(negedge clk);
        cfg_we  = 1'b1;
        cfg_sel = 3'(sel);
        cfg_val = 6'(val);
        @(negedge clk);
        cfg_we  = 1'b0;
    endtask

    task automatic set_cfg(input int sap, input int spa, input int rcd,
                           input int ras, input int rp, input int wrr);
        g_sap = sap; g_spa = spa; g_rcd = rcd; g_ras = ras; g_rp = rp; g_wrr = wrr;
        cfg_write(0, sap); cfg_write(1, spa); cfg_write(2, rcd);
        cfg_write(3, ras); cfg_write(4, rp);  cfg_write(5, wrr);
    endtask

    // run one request and compare the whole bus trace against the model
    task automatic run_op(input int bank, input int ra, input int rb, input int col,
                          input int mode, input int reps, input bit poke_cfg, input string tag);
        int k = 0, errs = 0, rel = 0, done_at = -1;
        bit rdy_bad = 0;
        build_exp(mode, reps, ra, rb, col);
        @(negedge clk);
        check(req_ready == 1'b1, {tag, " R6 ready before request"}, int'(req_ready), 1);
        req_valid = 1'b1;
        req_bank  = BANK_W'(bank);
        req_row_a = ROW_W'(ra);
        req_row_b = ROW_W'(rb);
        req_col   = COL_W'(col);
        req_mode  = 2'(mode);
        req_reps  = REP_W'(reps);
        while (done_at < 0 && rel < 6000) begin
            @(negedge clk);
            rel++;
            req_valid = 1'b0;
            if (poke_cfg) begin
                cfg_we  = (rel == 2);
                cfg_sel = 3'd0;
                cfg_val = 6'd9;
            end
            if (req_ready) rdy_bad = 1;
            if (cmd_o != 3'd0) begin
                if (!(k < n_exp && exp_t[k] == rel && exp_c[k] == int'(cmd_o) &&
                      exp_a[k] == int'(cmd_addr) && int'(cmd_bank) == bank &&
                      wr_stb == (cmd_o == 3'd4) && rd_stb == (cmd_o == 3'd3))) begin
                    if (errs == 0)
                        $display("FAIL %s R1/R8 cmd#%0d: actual t=%0d cmd=%0d addr=%0d bank=%0d, expected t=%0d cmd=%0d addr=%0d bank=%0d",
                                 tag, k, rel, cmd_o, cmd_addr, cmd_bank,
                                 (k < n_exp) ? exp_t[k] : -1, (k < n_exp) ? exp_c[k] : -1,
                                 (k < n_exp) ? exp_a[k] : -1, bank);
                    errs++;
                end
                k++;
            end else if (cmd_bank != '0 || cmd_addr != '0 || wr_stb || rd_stb) begin
                errs++;
            end
            if (done) done_at = rel;
        end
        cfg_we = 1'b0;
        check(errs == 0 && k == n_exp, {tag, " R1/R3/R4/R5/R8 trace"}, k - errs, n_exp);
        check(done_at == exp_done, {tag, " R2 done timing"}, done_at, exp_done);
        check(!rdy_bad, {tag, " R6 ready low while busy"}, int'(rdy_bad), 0);
        @(negedge clk);
        check(!busy && !done && req_ready, {tag, " R2 idle after done"}, int'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state at the ports
        check(cmd_o == 3'd0 && cmd_addr == '0 && cmd_bank == '0, "R9 reset command NOP", int'(cmd_o), 0);
        check(req_ready && !busy && !done && !wr_stb && !rd_stb, "R9 reset flags", int'(busy), 0);

        // R9: default timing registers
        run_op(1, 12, 13, 5, 0, 0, 0, "R9 defaults copy");
        run_op(2, 40, 41, 7, 2, 1, 0, "R9 defaults sig");

        // R7: write while busy ignored (sap poke to 9 during request, model keeps 2)
        run_op(3, 100, 101, 3, 1, 0, 1, "R7 busy write ignored");
        run_op(0, 100, 101, 3, 0, 0, 0, "R7 next after busy write");

        // R7: all zero values act as one
        set_cfg(0, 0, 0, 0, 0, 0);
        run_op(1, 5, 6, 1, 0, 0, 0, "R7 zero copy");
        run_op(1, 5, 6, 1, 1, 0, 0, "R7 zero bulk");
        run_op(1, 5, 6, 1, 2, 2, 0, "R7 zero sig");

        // sweep over timing, all three modes
        for (int a = 0; a < 3; a++)
          for (int b = 0; b < 3; b++)
            for (int c = 0; c < 2; c++)
              for (int d = 0; d < 2; d++)
                for (int e = 0; e < 2; e++)
                  for (int f = 0; f < 2; f++) begin
                      int idx = ((((a * 3 + b) * 2 + c) * 2 + d) * 2 + e) * 2 + f;
                      set_cfg(a, (b == 2) ? 3 : b, c ? 3 : 1, d ? 9 : 2, e ? 3 : 1, f ? 2 : 0);
                      run_op(idx % 4, (idx * 7) % 1024, (idx * 7 + 1) % 1024, idx % 64,
                             0, 0, 0, "R3 copy sweep");
                      run_op((idx + 1) % 4, (idx * 13) % 1024, (idx * 13 + 2) % 1024, (idx + 5) % 64,
                             1, 0, 0, "R4 bulk sweep");
                      run_op((idx + 2) % 4, (idx * 5) % 1024, (idx * 5 + 3) % 1024, (idx + 9) % 64,
                             2, 1 + (idx % 2), 0, "R5 sig sweep");
                  end

        // R3: unused mode code behaves as copy
        set_cfg(2, 1, 3, 6, 2, 2);
        run_op(2, 30, 31, 8, 3, 5, 0, "R3 mode code 3");
        // R5: repeat count 0 and 100
        run_op(1, 60, 62, 4, 2, 0, 0, "R5 zero reps");
        run_op(3, 70, 71, 9, 2, 100, 0, "R5 hundred reps");
        // R4: bulk ignores reps
        run_op(0, 80, 81, 2, 1, 7, 0, "R4 bulk reps ignored");

        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule